// File: doc/BRIEF.md
# Second-Operand Shifter with Carry

This block forms the second operand of a 32-bit data-processing datapath and the carry bit that goes with it. The usual source is a register value passed through one of five moves: logical left, logical right, arithmetic right, rotate right, or a one-bit rotate that brings the incoming carry in at the top. The move distance comes from a 5-bit field in the instruction or from the least significant byte of a second register. A separate source builds a constant by rotating an 8-bit value right by twice a 4-bit rotate count.

A register-sourced distance can be anywhere from 0 to 255, so the block gives defined results at exactly one word width and past it. The operand and the carry-out are registered once and cleared by a synchronous active-high reset. Deciding whether the carry reaches the flags is left to the datapath around the block.

Top module: `operand_shifter`

## Requirements
- R1: A synchronous active-high `rst` clears `op2` and `carry_out` to 0. Both outputs are registered and reflect the inputs sampled at the previous rising clock edge.
- R2: `shift_kind` 2'b00 is logical left. With a field distance n of 0..31 the result is `rm_val` shifted left by n with zeros shifted in. The carry is the last bit shifted out, or `carry_in` when n is 0.
- R3: `shift_kind` 2'b01 is logical right with zero fill, and the carry is the last bit shifted out. A field value of 0 encodes a distance of 32, which gives result 0 and carry equal to `rm_val` bit 31.
- R4: `shift_kind` 2'b10 is arithmetic right, filling with copies of `rm_val` bit 31, and the carry is the last bit shifted out. A field value of 0 encodes a distance of 32, which gives all copies of bit 31 and carry equal to bit 31.
- R5: `shift_kind` 2'b11 with a field of 1..31 rotates right: the low n bits move to the top. The carry is bit 31 of the result.
- R6: `shift_kind` 2'b11 with a field of 0 is the extended rotate. The result is `{carry_in, rm_val[31:1]}` and the carry is `rm_val` bit 0.
- R7: When `amt_from_reg` is 1, only `rs_val[7:0]` sets the distance. A distance of 0 passes `rm_val` unchanged with the carry equal to `carry_in`, for every shift kind.
- R8: For a register distance of 32, logical left gives 0 with carry equal to bit 0, and logical right gives 0 with carry equal to bit 31. For a register distance above 32, both give 0 with carry 0.
- R9: An arithmetic right shift with a register distance of 32 or more gives all copies of bit 31, with carry equal to bit 31.
- R10: A rotate with a register distance uses the distance modulo 32. A non-zero multiple of 32 leaves the value unchanged, with carry equal to bit 31.
- R11: When `use_imm8` is 1, `op2` is `imm8` zero-extended and rotated right by 2×`rot4`, and `rm_val` has no effect. The carry is bit 31 of that result when `rot4` is non-zero, and `carry_in` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| use_imm8 | input | 1 | Select the rotated 8-bit constant as the source |
| imm8 | input | 8 | Constant value |
| rot4 | input | 4 | Constant rotate count (counted in steps of two bits) |
| rm_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate |
| amt_from_reg | input | 1 | Take the distance from `rs_val` instead of the field |
| amt_field | input | 5 | Instruction-field distance |
| rs_val | input | 32 | Register supplying the distance (low byte used) |
| carry_in | input | 1 | Incoming carry flag |
| op2 | output | 32 | Registered second operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
The bench builds the block with its defaults: a 32-bit word, an 8-bit distance byte, and an 8-bit constant with a 4-bit rotate count. With these values, register distances of exactly 32, just above 32, 64 and 255 can all be applied, along with high bytes of `rs_val` that must be ignored. The constant rotate reaches 30 bits, which is enough to wrap constant bits across bit 31 and make them the carry.

// File: rtl/opshift_pkg.sv
package opshift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/opshift_amount.sv
module opshift_amount
  import opshift_pkg::*;
#(
  parameter int W       = 32,
  parameter int RS_BITS = 8,
  localparam int AW     = $clog2(W),
  localparam int AMT_W  = (RS_BITS > AW + 1) ? RS_BITS : AW + 1
) (
  input  shift_kind_e        kind,
  input  logic               from_reg,
  input  logic [AW-1:0]      field,
  input  logic [RS_BITS-1:0] rs_low,
  output logic [AMT_W-1:0]   amt,
  output logic               rrx
);
  always_comb begin
    amt = '0;
    rrx = 1'b0;
    if (from_reg) begin
      amt = AMT_W'(rs_low);
    end else begin
      unique case (kind)
        SH_LSL: amt = AMT_W'(field);
        SH_LSR,
        SH_ASR: amt = (field == '0) ? AMT_W'(W) : AMT_W'(field);
        SH_ROR: begin
          amt = AMT_W'(field);
          rrx = (field == '0);
        end
        default: amt = '0;
      endcase
    end
  end
endmodule

// File: rtl/opshift_barrel.sv
module opshift_barrel
  import opshift_pkg::*;
#(
  parameter int W      = 32,
  parameter int AMT_W  = 8,
  localparam int AW    = $clog2(W)
) (
  input  logic [W-1:0]     v,
  input  shift_kind_e      kind,
  input  logic [AMT_W-1:0] amt,
  input  logic             rrx,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  logic [W:0]        lsl_t;
  logic [W:0]        lsr_t;
  logic signed [W:0] asr_t;
  logic [AMT_W-1:0]  asr_amt;
  logic [AW-1:0]     ror_amt;
  logic [W-1:0]      ror_t;

  always_comb begin
    lsl_t   = {1'b0, v} << amt;
    lsr_t   = {v, 1'b0} >> amt;
    asr_amt = (amt > AMT_W'(W)) ? AMT_W'(W) : amt;
    asr_t   = $signed({v, 1'b0}) >>> asr_amt;
    ror_amt = amt[AW-1:0];
    ror_t   = (v >> ror_amt) | (v << (W - int'(ror_amt)));
  end

  always_comb begin
    res  = v;
    cout = cin;
    if (rrx) begin
      res  = {cin, v[W-1:1]};
      cout = v[0];
    end else if (amt != '0) begin
      unique case (kind)
        SH_LSL: begin res = lsl_t[W-1:0]; cout = lsl_t[W]; end
        SH_LSR: begin res = lsr_t[W:1];   cout = lsr_t[0]; end
        SH_ASR: begin res = asr_t[W:1];   cout = asr_t[0]; end
        SH_ROR: begin res = ror_t;        cout = ror_t[W-1]; end
        default: begin res = v; cout = cin; end
      endcase
    end
  end
endmodule

// File: rtl/opshift_immrot.sv
module opshift_immrot #(
  parameter int W     = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4,
  localparam int RA_W = ROT_W + 1
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [ROT_W-1:0] rot,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  logic [W-1:0]  base;
  logic [RA_W-1:0] ra;

  always_comb begin
    base = W'(imm);
    ra   = {rot, 1'b0};
    res  = (base >> ra) | (base << (W - int'(ra)));
    cout = (rot != '0) ? res[W-1] : cin;
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import opshift_pkg::*;
#(
  parameter int W       = 32,
  parameter int RS_BITS = 8,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  localparam int AW     = $clog2(W),
  localparam int AMT_W  = (RS_BITS > AW + 1) ? RS_BITS : AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_imm8,
  input  logic [IMM_W-1:0] imm8,
  input  logic [ROT_W-1:0] rot4,
  input  logic [W-1:0]     rm_val,
  input  logic [1:0]       shift_kind,
  input  logic             amt_from_reg,
  input  logic [AW-1:0]    amt_field,
  input  logic [W-1:0]     rs_val,
  input  logic             carry_in,
  output logic [W-1:0]     op2,
  output logic             carry_out
);
  shift_kind_e      kind;
  logic [AMT_W-1:0] amt;
  logic             rrx;
  logic [W-1:0]     sh_res;
  logic             sh_c;
  logic [W-1:0]     im_res;
  logic             im_c;
  logic             unused_rs_hi;

  assign kind         = shift_kind_e'(shift_kind);
  assign unused_rs_hi = ^rs_val[W-1:RS_BITS];

  opshift_amount #(.W(W), .RS_BITS(RS_BITS)) u_amt (
    .kind(kind), .from_reg(amt_from_reg), .field(amt_field),
    .rs_low(rs_val[RS_BITS-1:0]), .amt(amt), .rrx(rrx)
  );

  opshift_barrel #(.W(W), .AMT_W(AMT_W)) u_bar (
    .v(rm_val), .kind(kind), .amt(amt), .rrx(rrx), .cin(carry_in),
    .res(sh_res), .cout(sh_c)
  );

  opshift_immrot #(.W(W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm(imm8), .rot(rot4), .cin(carry_in), .res(im_res), .cout(im_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op2       <= '0;
      carry_out <= 1'b0;
    end else begin
      op2       <= use_imm8 ? im_res : sh_res;
      carry_out <= use_imm8 ? im_c : sh_c;
    end
  end
endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
  parameter int W       = 32,
  parameter int RS_BITS = 8,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  localparam int AW     = $clog2(W)
) (
  input logic             clk,
  input logic             rst,
  input logic             use_imm8,
  input logic [IMM_W-1:0] imm8,
  input logic [ROT_W-1:0] rot4,
  input logic [W-1:0]     rm_val,
  input logic [1:0]       shift_kind,
  input logic             amt_from_reg,
  input logic [AW-1:0]    amt_field,
  input logic [W-1:0]     rs_val,
  input logic             carry_in,
  input logic [W-1:0]     op2,
  input logic             carry_out
);
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (op2 == '0 && !carry_out));

  p_zero_dist_r7: assert property (@(posedge clk) disable iff (rst)
    (live && !use_imm8 && amt_from_reg && rs_val[RS_BITS-1:0] == '0)
    |=> (op2 == $past(rm_val) && carry_out == $past(carry_in)));

  p_extended_rot_r6: assert property (@(posedge clk) disable iff (rst)
    (live && !use_imm8 && !amt_from_reg && shift_kind == 2'b11 && amt_field == '0)
    |=> (carry_out == $past(rm_val[0]) && op2[W-1] == $past(carry_in)));

  p_logical_far_r8: assert property (@(posedge clk) disable iff (rst)
    (live && !use_imm8 && amt_from_reg && !shift_kind[1]
     && rs_val[RS_BITS-1:0] > RS_BITS'(W))
    |=> (op2 == '0 && !carry_out));

  p_arith_far_r9: assert property (@(posedge clk) disable iff (rst)
    (live && !use_imm8 && amt_from_reg && shift_kind == 2'b10
     && rs_val[RS_BITS-1:0] >= RS_BITS'(W))
    |=> (op2 == {W{$past(rm_val[W-1])}} && carry_out == $past(rm_val[W-1])));

  p_const_norot_r11: assert property (@(posedge clk) disable iff (rst)
    (live && use_imm8 && rot4 == '0)
    |=> (op2 == W'($past(imm8)) && carry_out == $past(carry_in)));
endmodule

bind operand_shifter operand_shifter_chk #(
  .W(W), .RS_BITS(RS_BITS), .IMM_W(IMM_W), .ROT_W(ROT_W)
) u_chk (
  .clk(clk), .rst(rst), .use_imm8(use_imm8), .imm8(imm8), .rot4(rot4),
  .rm_val(rm_val), .shift_kind(shift_kind), .amt_from_reg(amt_from_reg),
  .amt_field(amt_field), .rs_val(rs_val), .carry_in(carry_in),
  .op2(op2), .carry_out(carry_out)
);

// File: tb/sim_operand_shifter.sv
module sim_operand_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        use_imm8 = 1'b0;
  logic [7:0]  imm8 = '0;
  logic [3:0]  rot4 = '0;
  logic [31:0] rm_val = '0;
  logic [1:0]  shift_kind = '0;
  logic        amt_from_reg = 1'b0;
  logic [4:0]  amt_field = '0;
  logic [31:0] rs_val = '0;
  logic        carry_in = 1'b0;
  logic [31:0] op2;
  logic        carry_out;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  operand_shifter u0 (
    .clk(clk), .rst(rst), .use_imm8(use_imm8), .imm8(imm8), .rot4(rot4),
    .rm_val(rm_val), .shift_kind(shift_kind), .amt_from_reg(amt_from_reg),
    .amt_field(amt_field), .rs_val(rs_val), .carry_in(carry_in),
    .op2(op2), .carry_out(carry_out)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic        ui;
    logic [7:0]  imm;
    logic [3:0]  rot;
    logic [31:0] rm;
    logic [1:0]  kind;
    logic        fr;
    logic [4:0]  fld;
    logic [31:0] rs;
    logic        cin;
    logic [31:0] eop;
    logic        ec;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{"R2 ", 1'b0, 8'h00, 4'h0, 32'h1234_5678, 2'd0, 1'b0, 5'd4,  32'h0,         1'b0, 32'h2345_6780, 1'b1},
    '{"R2 ", 1'b0, 8'h00, 4'h0, 32'h8000_0001, 2'd0, 1'b0, 5'd0,  32'h0,         1'b1, 32'h8000_0001, 1'b1},
    '{"R2 ", 1'b0, 8'h00, 4'h0, 32'h0000_0003, 2'd0, 1'b0, 5'd31, 32'h0,         1'b0, 32'h8000_0000, 1'b1},
    '{"R2 ", 1'b0, 8'h00, 4'h0, 32'h8000_0000, 2'd0, 1'b0, 5'd1,  32'h0,         1'b0, 32'h0000_0000, 1'b1},
    '{"R3 ", 1'b0, 8'h00, 4'h0, 32'h8000_0001, 2'd1, 1'b0, 5'd1,  32'h0,         1'b0, 32'h4000_0000, 1'b1},
    '{"R3 ", 1'b0, 8'h00, 4'h0, 32'h8000_0001, 2'd1, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0000_0000, 1'b1},
    '{"R3 ", 1'b0, 8'h00, 4'h0, 32'h1234_5678, 2'd1, 1'b0, 5'd8,  32'h0,         1'b1, 32'h0012_3456, 1'b0},
    '{"R4 ", 1'b0, 8'h00, 4'h0, 32'h8765_4321, 2'd2, 1'b0, 5'd4,  32'h0,         1'b1, 32'hF876_5432, 1'b0},
    '{"R4 ", 1'b0, 8'h00, 4'h0, 32'h8000_0000, 2'd2, 1'b0, 5'd0,  32'h0,         1'b0, 32'hFFFF_FFFF, 1'b1},
    '{"R4 ", 1'b0, 8'h00, 4'h0, 32'h7FFF_FFFF, 2'd2, 1'b0, 5'd0,  32'h0,         1'b1, 32'h0000_0000, 1'b0},
    '{"R5 ", 1'b0, 8'h00, 4'h0, 32'h1234_5678, 2'd3, 1'b0, 5'd8,  32'h0,         1'b1, 32'h7812_3456, 1'b0},
    '{"R5 ", 1'b0, 8'h00, 4'h0, 32'h0000_000F, 2'd3, 1'b0, 5'd4,  32'h0,         1'b0, 32'hF000_0000, 1'b1},
    '{"R6 ", 1'b0, 8'h00, 4'h0, 32'h0000_0003, 2'd3, 1'b0, 5'd0,  32'h0,         1'b1, 32'h8000_0001, 1'b1},
    '{"R6 ", 1'b0, 8'h00, 4'h0, 32'h8000_0002, 2'd3, 1'b0, 5'd0,  32'h0,         1'b0, 32'h4000_0001, 1'b0},
    '{"R7 ", 1'b0, 8'h00, 4'h0, 32'h1234_5678, 2'd1, 1'b1, 5'd3,  32'h0000_0100, 1'b1, 32'h1234_5678, 1'b1},
    '{"R7 ", 1'b0, 8'h00, 4'h0, 32'h1234_5678, 2'd0, 1'b1, 5'd9,  32'hFFFF_FF04, 1'b0, 32'h2345_6780, 1'b1},
    '{"R7 ", 1'b0, 8'h00, 4'h0, 32'h8000_0001, 2'd3, 1'b1, 5'd0,  32'h0000_0000, 1'b0, 32'h8000_0001, 1'b0},
    '{"R7 ", 1'b0, 8'h00, 4'h0, 32'h8000_0001, 2'd2, 1'b1, 5'd0,  32'hABCD_EF00, 1'b1, 32'h8000_0001, 1'b1},
    '{"R8 ", 1'b0, 8'h00, 4'h0, 32'h0000_0001, 2'd0, 1'b1, 5'd0,  32'h0000_0020, 1'b0, 32'h0000_0000, 1'b1},
    '{"R8 ", 1'b0, 8'h00, 4'h0, 32'h8000_0000, 2'd1, 1'b1, 5'd0,  32'h0000_0020, 1'b0, 32'h0000_0000, 1'b1},
    '{"R8 ", 1'b0, 8'h00, 4'h0, 32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0,  32'h0000_0021, 1'b1, 32'h0000_0000, 1'b0},
    '{"R8 ", 1'b0, 8'h00, 4'h0, 32'hFFFF_FFFF, 2'd1, 1'b1, 5'd0,  32'h0000_00FF, 1'b1, 32'h0000_0000, 1'b0},
    '{"R9 ", 1'b0, 8'h00, 4'h0, 32'h8000_0000, 2'd2, 1'b1, 5'd0,  32'h0000_0020, 1'b0, 32'hFFFF_FFFF, 1'b1},
    '{"R9 ", 1'b0, 8'h00, 4'h0, 32'h4000_0000, 2'd2, 1'b1, 5'd0,  32'h0000_00C8, 1'b1, 32'h0000_0000, 1'b0},
    '{"R10", 1'b0, 8'h00, 4'h0, 32'h8000_0001, 2'd3, 1'b1, 5'd0,  32'h0000_0020, 1'b0, 32'h8000_0001, 1'b1},
    '{"R10", 1'b0, 8'h00, 4'h0, 32'h0000_000F, 2'd3, 1'b1, 5'd0,  32'h0000_0024, 1'b0, 32'hF000_0000, 1'b1},
    '{"R10", 1'b0, 8'h00, 4'h0, 32'h0000_0001, 2'd3, 1'b1, 5'd0,  32'h0000_0040, 1'b1, 32'h0000_0001, 1'b0},
    '{"R11", 1'b1, 8'hFF, 4'hF, 32'hDEAD_BEEF, 2'd1, 1'b0, 5'd3,  32'h0,         1'b1, 32'h0000_03FC, 1'b0},
    '{"R11", 1'b1, 8'h3F, 4'h0, 32'hDEAD_BEEF, 2'd0, 1'b0, 5'd7,  32'h0,         1'b1, 32'h0000_003F, 1'b1},
    '{"R11", 1'b1, 8'h02, 4'h1, 32'h1234_5678, 2'd3, 1'b1, 5'd0,  32'h0000_0005, 1'b0, 32'h8000_0000, 1'b1}
  };

  task automatic drive(input vec_t v);
    use_imm8     = v.ui;
    imm8         = v.imm;
    rot4         = v.rot;
    rm_val       = v.rm;
    shift_kind   = v.kind;
    amt_from_reg = v.fr;
    amt_field    = v.fld;
    rs_val       = v.rs;
    carry_in     = v.cin;
  endtask

  task automatic check(input string tag, input logic [31:0] eop, input logic ec);
    nchk++;
    if (op2 !== eop || carry_out !== ec) begin
      nfail++;
      $display("FAIL %s: op2=%h carry=%b expected op2=%h carry=%b",
               tag, op2, carry_out, eop, ec);
    end
  endtask

  initial begin
    #(20 * 20000);
    nfail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 1'b0);
    rst = 1'b0;

    // Main table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check(string'(VEC[i].tag), VEC[i].eop, VEC[i].ec);
    end

    // R1: outputs hold until the next rising edge
    drive(VEC[0]);
    #2;
    check("R1 hold", VEC[NV-1].eop, VEC[NV-1].ec);
    @(negedge clk);
    check("R1 update", VEC[0].eop, VEC[0].ec);

    // R1: reset applied while inputs are active
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", 32'h0, 1'b0);
    rst = 1'b0;

    // R11: rotate of 2 wraps constant bit 0 to bit 30
    drive('{"R11", 1'b1, 8'h81, 4'h1, 32'hFFFF_FFFF, 2'd0, 1'b0, 5'd0, 32'h0, 1'b1,
            32'h4000_0020, 1'b0});
    @(negedge clk);
    check("R11 wrap", 32'h4000_0020, 1'b0);

    // R10: rotate distance 255 acts as 31 (rotate left by one)
    drive('{"R10", 1'b0, 8'h00, 4'h0, 32'h8000_0001, 2'd3, 1'b1, 5'd0, 32'h0000_00FF, 1'b0,
            32'h0000_0003, 1'b0});
    @(negedge clk);
    check("R10 mod", 32'h0000_0003, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule